// File: doc/BRIEF.md
# Receive-Path Statistics Counter Bank

This block keeps a small set of event counters for a network receive path. Examples are frames that fail the CRC check, frames with an alignment error, and good unicast frames. Each counter has its own single-cycle strobe input and counts one event per cycle in which its strobe is high. One control word sets the policy for every counter at once:

- a freeze that makes the counters ignore events;
- clear-on-read;
- holding at the maximum value instead of wrapping to zero;
- a self-clearing command that zeroes all counters.

Software reads the counters, the control word, a sticky flag word and an interrupt mask through a simple register port. Read data appears one cycle after the address. Read side effects happen only while the read-enable strobe is high.

A counter raises its sticky flag when it climbs into the upper half of its range, that is, when its top bit goes from 0 to 1. The flag word is cleared by reading it. One level output reports any flag that is not masked.

Top module: `stat_counter_bank`

## Requirements
- R1: The control word is at byte address 0x100. Bit 0 is the clear-all command, bit 1 selects saturation, bit 2 selects clear-on-read and bit 3 is freeze. It resets to 0. Bits 31:4 ignore writes and always read as 0.
- R2: Writing a 1 to control bit 0 zeroes every counter on the following clock edge. The bit reads 1 for that one cycle and returns to 0 by itself. An event in the clearing cycle is lost, because the clear wins. Writing 0 to the bit leaves the counters as they are.
- R3: With control bit 1 at 0, a counter at its all-ones value goes to 0 on its next event. With the bit at 1, the counter stays at all-ones.
- R4: Counter i is read at byte address 4*i. It resets to 0 and increments by one in each cycle in which its strobe bit i is high.
- R5: With control bit 2 at 1, a read of a counter with read-enable high returns the counter's value before the read and leaves the counter at 0. If that counter's strobe is high in the same cycle, the counter ends at 1. With control bit 2 at 0, or with read-enable low, a read leaves the counter unchanged.
- R6: With control bit 3 at 1, every counter holds its value and ignores its strobe. A clear-on-read still zeroes a counter that is read while frozen.
- R7: Read data is registered. It shows the register selected by the read address of the previous cycle. Addresses with no register behind them read as 0.
- R8: The flag word is at byte address 0x104 and resets to 0. Counter 0 uses flag bit 5, counter 1 uses bit 6 and counter 2 uses bit 17; all other bits read 0. A flag is set when its counter's top bit goes from 0 to 1, and it stays set after the counter falls back. A read of 0x104 with read-enable high returns the flags and then clears them. A read with read-enable low leaves them set.
- R9: The mask word is at byte address 0x108 and resets to 0. Only the flag bit positions can be written; all other bits read 0. A mask bit of 1 blocks the flag in the same bit position. The interrupt output is registered: it goes high one cycle after any flag whose mask bit is 0 is set, and low one cycle after no such flag remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | NUM_CNT | Event strobes, one bit per counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; enables the read side effects |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: any flag whose mask bit is 0 |

## Verification
The counting path is driven with short bursts on different counters. These bursts separate the per-counter strobe decode and the address decode. Long bursts carry a counter across its half-range point and its all-ones value under each policy, which separates wrapping from saturation and shows the flag is sticky after a wrap. Reads are issued with read-enable high and low, with and without clear-on-read, while frozen, and in the same cycle as a strobe, which separates the pre-clear return value from the counter's state afterwards. The clear-all command is issued with a strobe held across the clearing edge, which shows the priority between clear and count and the one-cycle self-clearing of the command bit.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

  localparam int unsigned DATA_W = 32;

  localparam int unsigned CTRL_OFS = 32'h100;
  localparam int unsigned FLAG_OFS = 32'h104;
  localparam int unsigned MASK_OFS = 32'h108;

  localparam int unsigned CB_CLEAR  = 0;
  localparam int unsigned CB_SAT    = 1;
  localparam int unsigned CB_RDCLR  = 2;
  localparam int unsigned CB_FREEZE = 3;

  typedef struct packed {
    logic freeze;
    logic rd_clr;
    logic sat;
  } policy_t;

  // flag position of counter idx inside the flag word
  function automatic int unsigned flag_bit(input int unsigned idx);
    case (idx)
      0:       flag_bit = 5;
      1:       flag_bit = 6;
      2:       flag_bit = 17;
      default: flag_bit = 18 + (idx - 3);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] flag_field(input int unsigned n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < n; i++) m[flag_bit(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/stat_ctrl_regs.sv
module stat_ctrl_regs
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 3,
  parameter int unsigned ADDR_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output policy_t           pol,
  output logic              clr_pend,
  output logic [DATA_W-1:0] mask
);

  localparam logic [DATA_W-1:0] MASK_KEEP = flag_field(NUM_CNT);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(MASK_OFS);

  logic ctrl_hit;
  logic mask_hit;

  assign ctrl_hit = wr_en && (wr_addr == A_CTRL);
  assign mask_hit = wr_en && (wr_addr == A_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol      <= '0;
      clr_pend <= 1'b0;
      mask     <= '0;
    end else begin
      // command bit lives for exactly the cycle after the write
      clr_pend <= ctrl_hit && wr_data[CB_CLEAR];
      if (ctrl_hit) begin
        pol.sat    <= wr_data[CB_SAT];
        pol.rd_clr <= wr_data[CB_RDCLR];
        pol.freeze <= wr_data[CB_FREEZE];
      end
      if (mask_hit) mask <= wr_data & MASK_KEEP;
    end
  end

endmodule

// File: rtl/stat_counter.sv
module stat_counter
  import stat_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             clr_all,
  input  logic             rd_clear,
  input  policy_t          pol,
  output logic [CNT_W-1:0] cnt,
  output logic             half_hit
);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] stepped;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    base = rd_clear ? '0 : cnt;
    if (evt && !pol.freeze) begin
      if (&base) stepped = pol.sat ? base : '0;
      else       stepped = base + 1'b1;
    end else begin
      stepped = base;
    end
    nxt = clr_all ? '0 : stepped;
  end

  assign half_hit = nxt[CNT_W-1] && !cnt[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end

endmodule

// File: rtl/stat_flags.sv
module stat_flags
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] half_hit,
  input  logic               rd_clear,
  input  logic [DATA_W-1:0]  mask,
  output logic [DATA_W-1:0]  flags,
  output logic               irq
);

  logic [NUM_CNT-1:0] fl_q;

  genvar g;
  generate
    for (g = 0; g < NUM_CNT; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) fl_q[g] <= 1'b0;
        else     fl_q[g] <= half_hit[g] || (fl_q[g] && !rd_clear);
      end
    end
  endgenerate

  always_comb begin
    flags = '0;
    for (int unsigned i = 0; i < NUM_CNT; i++) flags[flag_bit(i)] = fl_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & ~mask);
  end

endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 3,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] evt_strobe,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic               irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

  policy_t                  pol_q;
  logic                     clr_pend;
  logic [DATA_W-1:0]        mask_q;
  logic [DATA_W-1:0]        flags;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]       half_hit;
  logic [NUM_CNT-1:0]       cnt_sel;
  logic [NUM_CNT-1:0]       cnt_rdclr;
  logic                     flag_rdclr;
  logic [DATA_W-1:0]        rd_mux;

  stat_ctrl_regs #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pol      (pol_q),
    .clr_pend (clr_pend),
    .mask     (mask_q)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CNT; g++) begin : g_cnt
      assign cnt_sel[g]   = (rd_addr == ADDR_W'(4 * g));
      assign cnt_rdclr[g] = rd_en && pol_q.rd_clr && cnt_sel[g];

      stat_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_strobe[g]),
        .clr_all  (clr_pend),
        .rd_clear (cnt_rdclr[g]),
        .pol      (pol_q),
        .cnt      (cnt_flat[g*CNT_W +: CNT_W]),
        .half_hit (half_hit[g])
      );
    end
  endgenerate

  assign flag_rdclr = rd_en && (rd_addr == A_FLAG);

  stat_flags #(.NUM_CNT(NUM_CNT)) flags_i (
    .clk      (clk),
    .rst      (rst),
    .half_hit (half_hit),
    .rd_clear (flag_rdclr),
    .mask     (mask_q),
    .flags    (flags),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_CTRL) begin
      rd_mux[CB_CLEAR]  = clr_pend;
      rd_mux[CB_SAT]    = pol_q.sat;
      rd_mux[CB_RDCLR]  = pol_q.rd_clr;
      rd_mux[CB_FREEZE] = pol_q.freeze;
    end else if (rd_addr == A_FLAG) begin
      rd_mux = flags;
    end else if (rd_addr == A_MASK) begin
      rd_mux = mask_q;
    end else begin
      for (int unsigned i = 0; i < NUM_CNT; i++)
        if (cnt_sel[i]) rd_mux = DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 3,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 9
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     clr_pend,
  input logic                     freeze,
  input logic                     sat,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [31:0]              rd_data,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [31:0]              flags,
  input logic [31:0]              mask,
  input logic                     irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_OFS);

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CTRL) |=> (rd_data[31:4] == '0)); // R1

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_pend |=> (cnt_flat == '0)); // R2

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clr_pend && !rd_en) |=> $stable(cnt_flat)); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(flags & ~mask))); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en && (rd_addr == A_FLAG)) |-> ((flags & $past(flags)) == $past(flags))); // R8

  genvar g;
  generate
    for (g = 0; g < NUM_CNT; g++) begin : g_sat
      AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sat && !clr_pend && !rd_en && (&cnt_flat[g*CNT_W +: CNT_W]))
          |=> (&cnt_flat[g*CNT_W +: CNT_W])); // R3
    end
  endgenerate

endmodule

bind stat_counter_bank stat_counter_bank_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clr_pend (clr_pend),
  .freeze   (pol_q.freeze),
  .sat      (pol_q.sat),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .cnt_flat (cnt_flat),
  .flags    (flags),
  .mask     (mask_q),
  .irq      (irq)
);

// File: tb/stat_counter_bank_tb_top.sv
`timescale 1ns/1ps
module stat_counter_bank_tb_top;

  localparam int unsigned NUM_CNT = 3;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned ADDR_W  = 9;

  localparam logic [ADDR_W-1:0] A_C0   = 9'h000;
  localparam logic [ADDR_W-1:0] A_C1   = 9'h004;
  localparam logic [ADDR_W-1:0] A_C2   = 9'h008;
  localparam logic [ADDR_W-1:0] A_CTRL = 9'h100;
  localparam logic [ADDR_W-1:0] A_FLAG = 9'h104;
  localparam logic [ADDR_W-1:0] A_MASK = 9'h108;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_CNT-1:0] evt_strobe = '0;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [31:0]        wr_data = '0;
  logic               rd_en = 1'b0;
  logic [ADDR_W-1:0]  rd_addr = '0;
  logic [31:0]        rd_data;
  logic               irq;
  logic               peek = 1'b0;
  logic               sample_req = 1'b0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  stat_counter_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .evt_strobe (evt_strobe),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .irq        (irq)
  );

  // monitor: a read accepted at a rising edge is compared at the next falling edge
  always @(posedge clk) sample_req <= rd_en | peek;

  always @(negedge clk) begin
    if (sample_req) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read data with no expected item, actual=%h", rd_data);
      end else begin
        e = sb_q.pop_front();
        if (rd_data !== e.exp) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, rd_data, e.exp);
        end
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic en,
                    input logic [31:0] e, input string tag);
    rd_addr = a;
    rd_en   = en;
    peek    = !en;
    sb_q.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_en = 1'b0;
    peek  = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_CNT-1:0] m, input int n);
    evt_strobe = m;
    repeat (n) @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  initial begin
    #(8ns * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // reset state
    rd(A_CTRL, 1'b1, 32'h0, "R1 ctrl reset");
    rd(A_FLAG, 1'b1, 32'h0, "R8 flags reset");
    rd(A_MASK, 1'b1, 32'h0, "R9 mask reset");
    rd(A_C0,   1'b1, 32'h0, "R4 counter reset");
    chk_irq(1'b0, "R9 irq reset");

    // reserved control bits
    wr(A_CTRL, 32'hFFFF_FFF6);
    rd(A_CTRL, 1'b1, 32'h6, "R1 reserved bits read zero");
    wr(A_CTRL, 32'h0);

    // per-counter counting, plain reads
    pulse(3'b001, 5);
    pulse(3'b010, 3);
    rd(A_C0, 1'b1, 32'd5, "R4 counter0");
    rd(A_C1, 1'b1, 32'd3, "R4 counter1");
    rd(A_C2, 1'b1, 32'd0, "R4 counter2 untouched");
    rd(A_C0, 1'b1, 32'd5, "R5 read without clear-on-read keeps value");
    rd(9'h0F0, 1'b1, 32'd0, "R7 unmapped address");

    // clear-on-read
    wr(A_CTRL, 32'h4);
    rd(A_C1, 1'b0, 32'd3, "R5 read-enable low no side effect");
    rd(A_C1, 1'b1, 32'd3, "R5 returns pre-clear value");
    rd(A_C1, 1'b1, 32'd0, "R5 cleared after read");
    // clear and event in the same cycle
    rd_addr = A_C0; rd_en = 1'b1; evt_strobe = 3'b001;
    sb_q.push_back('{exp: 32'd5, tag: "R5 read with event"});
    @(negedge clk);
    rd_en = 1'b0; evt_strobe = '0;
    rd(A_C0, 1'b1, 32'd1, "R5 clear plus event ends at one");

    // global clear
    wr(A_CTRL, 32'h0);
    pulse(3'b100, 7);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, 1'b1, 32'h1, "R2 command bit visible one cycle");
    rd(A_CTRL, 1'b1, 32'h0, "R2 command bit self-clears");
    rd(A_C2, 1'b1, 32'd0, "R2 counters zeroed");
    pulse(3'b100, 7);
    wr_addr = A_CTRL; wr_data = 32'h1; wr_en = 1'b1; evt_strobe = 3'b100;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    evt_strobe = '0;
    rd(A_C2, 1'b1, 32'd0, "R2 clear wins over event");
    pulse(3'b100, 2);
    wr(A_CTRL, 32'h0);
    rd(A_C2, 1'b1, 32'd2, "R2 writing zero has no effect");

    // wrap and flag
    pulse(3'b010, 255);
    rd(A_C1, 1'b1, 32'd255, "R3 reaches all-ones");
    idle(1);
    chk_irq(1'b1, "R9 irq from unmasked flag");
    pulse(3'b010, 1);
    rd(A_C1, 1'b1, 32'd0, "R3 wraps to zero");
    rd(A_FLAG, 1'b0, 32'h40, "R8 sticky after wrap, peek keeps");
    rd(A_FLAG, 1'b1, 32'h40, "R8 counter1 flag bit 6");
    rd(A_FLAG, 1'b1, 32'h0, "R8 cleared by read");
    idle(1);
    chk_irq(1'b0, "R9 irq drops with flags");

    // saturation, mask
    wr(A_CTRL, 32'h2);
    pulse(3'b001, 300);
    rd(A_C0, 1'b1, 32'd255, "R3 saturates");
    idle(1);
    chk_irq(1'b1, "R9 irq from counter0 flag");
    wr(A_MASK, 32'hFFFF_FFFF);
    idle(1);
    chk_irq(1'b0, "R9 masked flag blocks irq");
    rd(A_MASK, 1'b1, 32'h0002_0060, "R9 mask keeps flag positions only");
    rd(A_FLAG, 1'b1, 32'h20, "R8 counter0 flag bit 5");
    wr(A_MASK, 32'h0);
    idle(1);
    chk_irq(1'b0, "R9 no flag no irq");

    // freeze
    wr(A_CTRL, 32'h0);
    pulse(3'b100, 4);
    wr(A_CTRL, 32'h8);
    pulse(3'b111, 10);
    rd(A_C2, 1'b0, 32'd6, "R6 frozen counter2 holds");
    rd(A_C1, 1'b1, 32'd0, "R6 frozen counter1 holds");
    wr(A_CTRL, 32'hC);
    rd(A_C2, 1'b1, 32'd6, "R6 read while frozen");
    rd(A_C2, 1'b1, 32'd0, "R6 clear-on-read while frozen");
    rd(A_C0, 1'b1, 32'd255, "R6 frozen counter0 kept value");

    idle(3);
    if (sb_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: %0d expected reads left, expected=0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule